// File: doc/BRIEF.md
# Oscillator Auto-Trim Controller

This block tunes a fast on-chip oscillator against a slow, accurate 32.768 kHz reference. All of its logic runs on the oscillator clock itself. The reference is brought into that domain through a two-flop synchroniser. Over a programmable window of reference periods the block counts oscillator cycles and compares the total with the nominal value. At the end of each window it moves a trim code one step toward the target. The default nominal count is 675 cycles per reference period, which puts the oscillator near 22.1184 MHz.

When the measured count lands within one cycle of the nominal value, the block reports lock and keeps monitoring. It gives up in two cases: when a run of trim updates reaches a retry limit without locking, or when the reference stops toggling. In either case it raises a status flag and clears its own enable bit. Two of the status flags can drive an interrupt line.

Software controls the block through a plain single-cycle register port. A write takes effect on the clock edge where `bus_en_i` and `bus_we_i` are both high, and read data is combinational from `bus_addr_i`. Nothing streams through the block, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `osc_autotrim`

## Requirements
- R1: Writing 1 to control bit 0 (word address 0) enables trimming. At the end of each window the trim code moves by exactly one step: down when the count exceeds nominal+1, up when it is below nominal-1. While the block is disabled the trim code does not change.
- R2: Control bits 5:4 hold a window code L. The window spans 4<<L reference periods (4, 8, 16 or 32), counted from a first reference rising edge that only arms the window. The nominal count is CYC_PER_REF*(4<<L).
- R3: The retry limit is RETRY_BASE<<L trim updates (64 to 512 by default). When the update counter reaches the limit without lock, status bit 1 (fail) sets and the enable bit clears.
- R4: A window whose count is within ±1 of nominal sets status bit 0 (lock), leaves the trim code unchanged and resets the update counter. Lock reads 0 while the block is disabled.
- R5: If no reference rising edge arrives within 2*CYC_PER_REF oscillator cycles while the block is enabled, status bit 2 (reference error) sets and the enable bit clears.
- R6: Status bits 1 and 2 are cleared by writing 1 to them at word address 2. Writing 0 to them has no effect.
- R7: `irq_o` is high when status bit 1 and enable bit 1, or status bit 2 and enable bit 2, are both set. The enable bits are at word address 1. Lock never raises the interrupt.
- R8: The trim code saturates at 0 and at its all-ones maximum instead of wrapping.
- R9: After reset the trim code is 1<<(TRIM_W-1), every register reads 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock being trimmed |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Asynchronous low-frequency reference |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 2 | Word address: 0 control, 1 interrupt enable, 2 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| trim_o | output | TRIM_W | Trim code to the oscillator |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench models an oscillator whose reference period, measured in clock cycles, follows the trim code. It checks the exact sequence of trim steps, so a design that steps by two or in the wrong direction shows up as a mismatch. It also measures the delay from enable to the first step for two window codes; a window counted over the wrong number of periods misses the expected range.

One scenario locks, holds lock for more windows than the retry limit, and then pushes the target out of reach. The fail flag must then follow exactly the full limit of further updates. A design that kept the counter across lock would fail too early, and one that wrapped the code at either end would show an unexpected step. Stopping the reference checks that the timeout disables the block, and the write-1-to-clear tests confirm that a write of 0 leaves a pending interrupt in place.

// File: rtl/atrim_pkg.sv
`timescale 1ns/1ps
package atrim_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_IEN  = 2'd1,
    REG_STAT = 2'd2
  } atrim_reg_e;

  localparam int BIT_EN      = 0;
  localparam int BIT_LOCK    = 0;
  localparam int BIT_FAIL    = 1;
  localparam int BIT_REFERR  = 2;
  localparam int LOOP_LSB    = 4;
  localparam int MAX_WINDOW  = 32;
endpackage

// File: rtl/atrim_ref_sync.sv
`timescale 1ns/1ps
module atrim_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ref_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/atrim_window.sv
`timescale 1ns/1ps
module atrim_window #(
  parameter int CYC_PER_REF = 675,
  parameter int CNT_W       = 17,
  parameter int GAP_W       = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic [1:0]       loop_i,
  output logic             done_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             ref_err_o
);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(2 * CYC_PER_REF);

  logic             armed_q;
  logic [5:0]       edges_q;
  logic [5:0]       last_edge;
  logic [CNT_W-1:0] cyc_q, cyc_inc;
  logic [GAP_W-1:0] gap_q;

  assign last_edge = (6'd4 << loop_i) - 6'd1;
  assign cyc_inc   = (cyc_q == '1) ? cyc_q : cyc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0; edges_q <= '0; cyc_q <= '0; gap_q <= '0;
      done_o <= 1'b0; meas_o <= '0; ref_err_o <= 1'b0;
    end else if (!run_i) begin
      armed_q <= 1'b0; edges_q <= '0; cyc_q <= '0; gap_q <= '0;
      done_o <= 1'b0; ref_err_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      ref_err_o <= 1'b0;
      if (rise_i)                gap_q <= '0;
      else if (gap_q == GAP_LIM) ref_err_o <= 1'b1;
      else                       gap_q <= gap_q + 1'b1;

      if (rise_i) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          edges_q <= '0;
          cyc_q   <= '0;
        end else if (edges_q == last_edge) begin
          done_o  <= 1'b1;
          meas_o  <= cyc_inc;
          edges_q <= '0;
          cyc_q   <= '0;
        end else begin
          edges_q <= edges_q + 1'b1;
          cyc_q   <= cyc_inc;
        end
      end else if (armed_q) begin
        cyc_q <= cyc_inc;
      end
    end
  end
endmodule

// File: rtl/atrim_stepper.sv
`timescale 1ns/1ps
module atrim_stepper #(
  parameter int          CYC_PER_REF = 675,
  parameter int          RETRY_BASE  = 64,
  parameter int          TRIM_W      = 9,
  parameter int          TRIM_RST    = 256,
  parameter int          CNT_W       = 17,
  parameter int          RTY_W       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  meas_i,
  input  logic [1:0]        loop_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              lock_o,
  output logic              give_up_o
);
  logic [CNT_W:0]       exp_w, meas_w;
  logic                 too_fast, too_slow;
  logic [RTY_W-1:0]     limit, retry_q;
  logic                 lock_q;
  logic [TRIM_W-1:0]    trim_next;

  assign exp_w    = (CNT_W+1)'(CYC_PER_REF) << ({1'b0, loop_i} + 3'd2);
  assign meas_w   = {1'b0, meas_i};
  assign too_fast = meas_w > exp_w + 1'b1;
  assign too_slow = meas_w + 1'b1 < exp_w;
  assign limit    = RTY_W'(RETRY_BASE) << loop_i;

  always_comb begin
    trim_next = trim_o;
    if (too_fast && trim_o != '0)      trim_next = trim_o - 1'b1;
    else if (too_slow && trim_o != '1) trim_next = trim_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_o    <= TRIM_W'(TRIM_RST);
      retry_q   <= '0;
      lock_q    <= 1'b0;
      give_up_o <= 1'b0;
    end else begin
      give_up_o <= 1'b0;
      if (!run_i) begin
        lock_q  <= 1'b0;
        retry_q <= '0;
      end else if (done_i) begin
        if (!too_fast && !too_slow) begin
          lock_q  <= 1'b1;
          retry_q <= '0;
        end else begin
          lock_q <= 1'b0;
          trim_o <= trim_next;
          if (retry_q + 1'b1 == limit) begin
            give_up_o <= 1'b1;
            retry_q   <= '0;
          end else begin
            retry_q <= retry_q + 1'b1;
          end
        end
      end
    end
  end

  assign lock_o = lock_q & run_i;
endmodule

// File: rtl/osc_autotrim.sv
`timescale 1ns/1ps
module osc_autotrim
  import atrim_pkg::*;
#(
  parameter int CYC_PER_REF = 675,
  parameter int RETRY_BASE  = 64,
  parameter int TRIM_W      = 9,
  parameter int TRIM_RST    = 1 << (TRIM_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(CYC_PER_REF * MAX_WINDOW * 4 + 1);
  localparam int GAP_W = $clog2(2 * CYC_PER_REF + 2);
  localparam int RTY_W = $clog2(RETRY_BASE * 8 + 1);

  logic             en_q, ie_fail_q, ie_ref_q, fail_q, referr_q;
  logic [1:0]       loop_q;
  logic             rise, done, ref_err, give_up, lock;
  logic [CNT_W-1:0] meas;
  logic             wr;
  logic             unused_wdata;

  assign wr           = bus_en_i & bus_we_i;
  assign unused_wdata = ^{bus_wdata_i[31:6], bus_wdata_i[3]};

  atrim_ref_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_clk_i), .rise_o(rise)
  );

  atrim_window #(.CYC_PER_REF(CYC_PER_REF), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_q), .rise_i(rise), .loop_i(loop_q),
    .done_o(done), .meas_o(meas), .ref_err_o(ref_err)
  );

  atrim_stepper #(
    .CYC_PER_REF(CYC_PER_REF), .RETRY_BASE(RETRY_BASE), .TRIM_W(TRIM_W),
    .TRIM_RST(TRIM_RST), .CNT_W(CNT_W), .RTY_W(RTY_W)
  ) u_stepper (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_q), .done_i(done), .meas_i(meas),
    .loop_i(loop_q), .trim_o(trim_o), .lock_o(lock), .give_up_o(give_up)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; loop_q <= '0; ie_fail_q <= 1'b0; ie_ref_q <= 1'b0;
      fail_q <= 1'b0; referr_q <= 1'b0;
    end else begin
      if (give_up || ref_err)            en_q <= 1'b0;
      else if (wr && bus_addr_i == REG_CTRL) en_q <= bus_wdata_i[BIT_EN];
      if (wr && bus_addr_i == REG_CTRL)  loop_q <= bus_wdata_i[LOOP_LSB+1:LOOP_LSB];
      if (wr && bus_addr_i == REG_IEN) begin
        ie_fail_q <= bus_wdata_i[BIT_FAIL];
        ie_ref_q  <= bus_wdata_i[BIT_REFERR];
      end
      if (give_up) fail_q <= 1'b1;
      else if (wr && bus_addr_i == REG_STAT && bus_wdata_i[BIT_FAIL]) fail_q <= 1'b0;
      if (ref_err) referr_q <= 1'b1;
      else if (wr && bus_addr_i == REG_STAT && bus_wdata_i[BIT_REFERR]) referr_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_CTRL: begin
        bus_rdata_o[BIT_EN] = en_q;
        bus_rdata_o[LOOP_LSB+1:LOOP_LSB] = loop_q;
      end
      REG_IEN: begin
        bus_rdata_o[BIT_FAIL]   = ie_fail_q;
        bus_rdata_o[BIT_REFERR] = ie_ref_q;
      end
      REG_STAT: begin
        bus_rdata_o[BIT_LOCK]   = lock;
        bus_rdata_o[BIT_FAIL]   = fail_q;
        bus_rdata_o[BIT_REFERR] = referr_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = (fail_q & ie_fail_q) | (referr_q & ie_ref_q);
endmodule

// File: rtl/atrim_chk.sv
`timescale 1ns/1ps
module atrim_chk #(
  parameter int TRIM_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              lock,
  input logic              fail,
  input logic              referr,
  input logic [TRIM_W-1:0] trim,
  input logic              irq
);
  AST_TRIM_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trim) |-> (trim == $past(trim) + 1'b1) || (trim == $past(trim) - 1'b1)); // R1
  AST_IDLE_TRIM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(trim)); // R1
  AST_FAIL_STOPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail) |-> !en); // R3
  AST_LOCK_HOLDS_TRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock) |-> $stable(trim)); // R4
  AST_REFERR_STOPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(referr) |-> !en); // R5
  AST_LOCK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && !fail && !referr) |-> !irq); // R7
endmodule

bind osc_autotrim atrim_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en_q), .lock(lock), .fail(fail_q),
  .referr(referr_q), .trim(trim_o), .irq(irq_o)
);

// File: tb/osc_autotrim_bench.sv
`timescale 1ns/1ps
module osc_autotrim_bench;
  localparam int CPR = 40;
  localparam int TW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_clk = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [TW-1:0] trim_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  int t0 = 20;
  logic ref_run = 1'b1;
  logic [TW-1:0] sb_q[$];
  logic [TW-1:0] last_trim;
  int cycles = 0;

  always #4 clk = ~clk;

  osc_autotrim #(.CYC_PER_REF(CPR), .RETRY_BASE(8), .TRIM_W(TW)) u_osc_autotrim (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .bus_en_i(bus_en),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .trim_o(trim_o), .irq_o(irq_o)
  );

  // Oscillator model: reference period in clock cycles grows with the trim code.
  initial begin
    forever begin
      if (ref_run) begin
        int p;
        p = CPR + int'(trim_o) - t0;
        if (p < 6) p = 6;
        ref_clk = 1'b1;
        repeat (p / 2) @(negedge clk);
        ref_clk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // Scoreboard monitor: every trim change must match the next expected code.
  always @(negedge clk) begin
    if (!rst_n) begin
      last_trim = trim_o;
    end else if (trim_o !== last_trim) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected trim step: actual %0d expected %0d", trim_o, last_trim);
      end else begin
        logic [TW-1:0] e;
        e = sb_q.pop_front();
        if (e !== trim_o) begin
          errors++;
          $display("FAIL R1 trim step: actual %0d expected %0d", trim_o, e);
        end
      end
      last_trim = trim_o;
    end
  end

  task automatic push_steps(input int from, input int to);
    int v = from;
    while (v != to) begin
      v = (to > v) ? v + 1 : v - 1;
      sb_q.push_back(TW'(v));
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic wait_stat(input int bitpos, input int maxc);
    logic [31:0] d;
    for (int i = 0; i < maxc; i++) begin
      rd(2'd2, d);
      if (d[bitpos]) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sb_q.delete();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic measure_first_step(output int n);
    n = 0;
    while (trim_o == TW'(16) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    do_reset();
    // R9 reset state
    chk("R9", "trim after reset", int'(trim_o), 16);
    chk("R9", "irq after reset", int'(irq_o), 0);
    rd(2'd0, d); chk("R9", "ctrl after reset", int'(d), 0);
    rd(2'd2, d); chk("R9", "status after reset", int'(d), 0);

    // Scenario A: lock at loop 0, hold lock past the retry limit, then lose target.
    t0 = 20;
    wr(2'd1, 32'h6);
    push_steps(16, 20);
    wr(2'd0, 32'h1);
    measure_first_step(n);
    chk_range("R2", "cycles to first step, 4-period window", n, 144, 192);
    wait_stat(0, 3000);
    rd(2'd2, d);
    chk("R4", "lock status", int'(d[0]), 1);
    chk("R1", "trim at lock", int'(trim_o), 20);
    chk("R7", "lock raises no irq", int'(irq_o), 0);
    repeat (2000) @(negedge clk);
    rd(2'd0, d);
    chk("R4", "still enabled after many locked windows", int'(d[0]), 1);
    t0 = 45;
    push_steps(20, 28);
    wait_stat(1, 3000);
    rd(2'd2, d);
    chk("R3", "fail flag after full limit", int'(d[1]), 1);
    chk("R4", "updates after lock equal full limit", int'(trim_o), 28);
    rd(2'd0, d);
    chk("R3", "enable cleared on fail", int'(d[0]), 0);
    chk("R7", "irq on fail with enable", int'(irq_o), 1);
    wr(2'd2, 32'h0);
    rd(2'd2, d);
    chk("R6", "write 0 keeps fail", int'(d[1]), 1);
    chk("R6", "irq kept after write 0", int'(irq_o), 1);
    wr(2'd2, 32'h2);
    rd(2'd2, d);
    chk("R6", "write 1 clears fail", int'(d[1]), 0);
    chk("R7", "irq drops after clear", int'(irq_o), 0);
    chk("R1", "all expected steps seen", sb_q.size(), 0);

    // Scenario B: window length for loop code 2.
    do_reset();
    t0 = 20;
    push_steps(16, 17);
    wr(2'd0, 32'h21);
    measure_first_step(n);
    chk_range("R2", "cycles to first step, 16-period window", n, 576, 624);
    wr(2'd0, 32'h0);
    repeat (700) @(negedge clk);
    chk("R1", "no step while disabled", int'(trim_o), 17);

    // Scenario C: high saturation, loop 1 limit 16, interrupt masked.
    do_reset();
    t0 = 45;
    push_steps(16, 31);
    wr(2'd0, 32'h11);
    wait_stat(1, 8000);
    chk("R8", "trim saturates high", int'(trim_o), 31);
    rd(2'd0, d);
    chk("R3", "enable cleared at loop-1 limit", int'(d[0]), 0);
    chk("R7", "fail masked without enable", int'(irq_o), 0);
    chk("R8", "all expected steps seen", sb_q.size(), 0);

    // Scenario D: low saturation, loop 2 limit 32.
    do_reset();
    t0 = -10;
    push_steps(16, 0);
    wr(2'd0, 32'h21);
    wait_stat(1, 40000);
    rd(2'd2, d);
    chk("R3", "fail at loop-2 limit", int'(d[1]), 1);
    chk("R8", "trim saturates low", int'(trim_o), 0);
    chk("R8", "all expected steps seen", sb_q.size(), 0);

    // Scenario E: dead reference.
    do_reset();
    t0 = 20;
    ref_run = 1'b0;
    repeat (100) @(negedge clk);
    wr(2'd1, 32'h4);
    wr(2'd0, 32'h1);
    repeat (120) @(negedge clk);
    rd(2'd2, d);
    chk("R5", "reference error flag", int'(d[2]), 1);
    chk("R5", "no lock on dead reference", int'(d[0]), 0);
    rd(2'd0, d);
    chk("R5", "enable cleared on reference error", int'(d[0]), 0);
    chk("R7", "irq on reference error", int'(irq_o), 1);
    chk("R5", "trim untouched", int'(trim_o), 16);
    wr(2'd2, 32'h4);
    rd(2'd2, d);
    chk("R6", "write 1 clears reference error", int'(d[2]), 0);
    chk("R7", "irq drops after clear", int'(irq_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule